// File: doc/BRIEF.md
# Single-Read-Port General-Purpose Register Bank

This block holds the general-purpose registers of a multi-cycle RISC datapath: thirty-two 32-bit entries behind one write port and one read port. Because only one read port exists, the controller fetches the two source operands in successive cycles and parks each in staging registers outside this block.

A write takes place on the rising clock edge when the active-low write strobe is low. The write index is decoded into one enable per entry, so exactly one entry at most changes per edge. Entry 0 has no storage and always returns zero. Reading is combinational from the read index. While the active-low read strobe is high, the read output is driven to all zeros and not left floating. Reset is asynchronous and active-low, and it clears every entry.

Top module: `gpr_bank_1r1w`

## Requirements
- R1: While rst_ni is low, and after it is released, every entry reads as zero until that entry is written.
- R2: When wr_en_ni is 0 at a rising clock edge, wr_data_i is stored in the entry selected by wr_addr_i. The new value is visible on rd_data_o right after that edge.
- R3: When wr_en_ni is 1 at a rising clock edge, no entry changes, whatever wr_addr_i and wr_data_i hold.
- R4: Entry 0 (wr_addr_i/rd_addr_i = 5'd0) always reads as zero. Writes aimed at it are discarded.
- R5: When rd_en_ni is 0, rd_data_o equals the entry at rd_addr_i, with no clock edge in between. When rd_en_ni is 1, rd_data_o is 32'h0.
- R6: When one cycle writes and reads the same index, the read returns the old value until the capturing edge, and the new value after it.
- R7: A write changes only the addressed entry. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_i | input | 5 | Read index |
| rd_en_ni | input | 1 | Read strobe, active low; output is zero when high |
| rd_data_o | output | 32 | Read data |
| wr_addr_i | input | 5 | Write index |
| wr_data_i | input | 32 | Write data |
| wr_en_ni | input | 1 | Write strobe, active low |

## Verification
The case hardest to bring about from the ports is the read of an index in the same cycle that it is being written. The returned value must be the old content before the edge and the new content after it, with the read strobe held low throughout. The bench drives both ports to the same index with a known old value, then samples once before the capturing edge and once after it. A long pseudo-random run against a reference array mixes writes to entry 0 and writes with the strobe high. This exposes any enable leaking into neighbouring entries.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  parameter int unsigned GPR_NUM = 32;
  parameter int unsigned GPR_W   = 32;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode #(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic                wr_en_ni,
  output logic [NUM_REGS-1:1] sel_o
);
  // entry 0 has no enable: writes to it vanish here
  always_comb begin
    for (int i = 1; i < NUM_REGS; i++) begin
      sel_o[i] = !wr_en_ni && (wr_addr_i == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_REGS-1:1]                sel_i,
  input  logic [DATA_W-1:0]                  wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]    q_o
);
  assign q_o[0] = '0;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= '0;
      else if (sel_i[i]) q <= wr_data_i;
    end
    assign q_o[i] = q;

    p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[i] |=> (q_o[i] == $past(wr_data_i)));
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[i] |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] q_i,
  input  logic [ADDR_W-1:0]               rd_addr_i,
  input  logic                            rd_en_ni,
  output logic [DATA_W-1:0]               rd_data_o
);
  // zeros stand in for a released bus
  assign rd_data_o = rd_en_ni ? '0 : q_i[rd_addr_i];
endmodule

// File: rtl/gpr_bank_1r1w.sv
module gpr_bank_1r1w
  import gpr_pkg::*;
#(
  parameter int unsigned NUM_REGS = GPR_NUM,
  parameter int unsigned DATA_W   = GPR_W,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              rd_en_ni,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_ni
);
  logic [NUM_REGS-1:1]             sel;
  logic [NUM_REGS-1:0][DATA_W-1:0] q;

  gpr_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr_addr_i (wr_addr_i),
    .wr_en_ni  (wr_en_ni),
    .sel_o     (sel)
  );

  gpr_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .wr_data_i (wr_data_i),
    .q_o       (q)
  );

  gpr_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
    .q_i       (q),
    .rd_addr_i (rd_addr_i),
    .rd_en_ni  (rd_en_ni),
    .rd_data_o (rd_data_o)
  );

  p_sel_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  p_idle_no_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_ni |-> (sel == '0));
  p_rd_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_ni |-> (rd_data_o == '0));
  p_zero_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_ni && rd_addr_i == '0) |-> (rd_data_o == '0));
  p_wr_zero_no_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_addr_i == '0) |-> (sel == '0));
endmodule

// File: tb/gpr_bank_1r1w_tb.sv
module gpr_bank_1r1w_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic        rd_en_n = 1'b1;
  logic [31:0] rd_data;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_en_n = 1'b1;

  int unsigned nvec = 0;
  int unsigned nerr = 0;
  logic [31:0] ref_m [32];

  always #2 clk = ~clk;

  gpr_bank_1r1w u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_addr_i(rd_addr), .rd_en_ni(rd_en_n), .rd_data_o(rd_data),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_en_ni(wr_en_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one edge: drive at negedge, edge passes, model updates
  task automatic wr_cycle(input logic [4:0] a, input logic [31:0] d, input logic en_n);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en_n = en_n;
    @(posedge clk);
    if (!en_n && a != 0) ref_m[a] = d;
    @(negedge clk);
    wr_en_n = 1'b1;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a);
    rd_addr = a; rd_en_n = 1'b0;
    #1;
    chk(req, rd_data, ref_m[a]);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) ref_m[i] = '0;
    rd_en_n = 1'b0;
    rd_addr = 5'd7; #1;
    chk("R1 during reset", rd_data, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i += 9) rd_chk("R1 after reset", 5'(i));
  endtask

  task automatic t_basic;
    wr_cycle(5'd1,  32'hDEADBEEF, 1'b0);
    wr_cycle(5'd31, 32'h12345678, 1'b0);
    wr_cycle(5'd16, 32'hA5A5A5A5, 1'b0);
    rd_chk("R2 entry 1", 5'd1);
    rd_chk("R2 entry 31", 5'd31);
    rd_chk("R2 entry 16", 5'd16);
    rd_chk("R7 neighbour 15", 5'd15);
    rd_chk("R7 neighbour 17", 5'd17);
  endtask

  task automatic t_idle_write;
    wr_cycle(5'd1, 32'h0BAD0BAD, 1'b1);
    rd_chk("R3 strobe high", 5'd1);
  endtask

  task automatic t_zero_entry;
    wr_cycle(5'd0, 32'hFFFFFFFF, 1'b0);
    rd_chk("R4 entry 0", 5'd0);
    rd_chk("R4 entry 1 untouched", 5'd1);
  endtask

  task automatic t_rd_gate;
    rd_addr = 5'd31; rd_en_n = 1'b1; #1;
    chk("R5 strobe high", rd_data, 32'h0);
    rd_en_n = 1'b0; #1;
    chk("R5 combinational", rd_data, 32'h12345678);
    rd_addr = 5'd16; #1;
    chk("R5 address change", rd_data, 32'hA5A5A5A5);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_addr = 5'd16; wr_data = 32'h5A5A0001; wr_en_n = 1'b0;
    rd_addr = 5'd16; rd_en_n = 1'b0;
    #1;
    chk("R6 before edge", rd_data, 32'hA5A5A5A5);
    @(posedge clk); #1;
    ref_m[16] = 32'h5A5A0001;
    chk("R6 after edge", rd_data, 32'h5A5A0001);
    @(negedge clk); wr_en_n = 1'b1;
  endtask

  task automatic t_random;
    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      logic [31:0] d;
      logic en;
      a = 5'($urandom_range(0, 31));
      d = $urandom;
      en = ($urandom_range(0, 3) == 0);
      wr_cycle(a, d, en);
      rd_chk("R7 random read", 5'($urandom_range(0, 31)));
      rd_chk("R2 random readback", a);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_idle_write();
    t_zero_entry();
    t_rd_gate();
    t_same_cycle();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule